// File: doc/BRIEF.md
# ECC Error Control and Status Register Unit

This unit sits next to the ECC encoder and decoder of a memory controller. It holds the software-visible control settings for error checking. It also keeps a record of the error events that the decoder reports. A word-addressed register port gives access to three 32-bit registers: control at word offset 0x130, status at 0x131 and error address at 0x132.

The control register drives the enable for ECC generation and checking, and the enable for auto-correction. It also sets two test-only injection modes that corrupt the low bits of every write data word on its way to memory. The decoder reports single-bit, double-bit and dropped-correction events as one-cycle pulses, together with the burst-aligned address of the access. The unit turns these pulses into sticky flags and saturating 8-bit counters, and it keeps the address of the latest single-bit or double-bit error.

A registered interrupt output is gated by a global enable and by a mask for each event class. Writing a self-clearing clear bit wipes the interrupt, the flags, the counters and the captured address at once.

Top module: `ecc_err_csr`

## Requirements
- R1: After reset the control register reads 0x0000_0011 (ECC enable and interrupt enable set, all else 0). The status and error address registers read 0, and irq is 0.
- R2: A write to offset 0x130 loads control bits 8:0 from write data. The control fields are: bit0 ECC enable, bit1 auto-correct enable, bit2 single-error inject, bit3 double-error inject, bit4 interrupt enable, bit5 single mask, bit6 double mask, bit7 clear, bit8 dropped mask. Bits 31:9 read 0. ecc_check_en follows bit0 and auto_corr_en follows bit1.
- R3: While bit0 is 1, write data passes with bit 0 inverted if bit2 is set, and with bits 0 and 1 inverted if bit3 is set (bits 0 and 1 also when both are set). While bit0 is 0, write data passes unchanged. Bits above 1 are never touched. The output is combinational.
- R4: Status bits 0, 1 and 2 are sticky flags for the single, double and dropped classes. Each sets on the clock edge of its first event and holds until a clear.
- R5: Status bits 15:8, 23:16 and 31:24 count single, double and dropped events, one per event pulse. Each count stops at 255 and does not wrap. Status bits 7:3 read 0.
- R6: Offset 0x132 captures ev_addr on each single-bit or double-bit event and keeps the most recent one. Dropped-correction events do not change it.
- R7: A write to 0x130 with bit7 set clears the flags, the counters, the error address and irq on that same clock edge. Bit7 then reads 1 for one cycle and 0 afterwards, unless it is written again.
- R8: An event in the same cycle as a clear is discarded. Flags and counts are 0 after that edge.
- R9: irq is a register. After each edge it equals the value, just before that edge, of: interrupt enable AND any flag whose class mask is 0. A clear in that cycle forces it to 0. It therefore rises one cycle after the flag.
- R10: Writes to offsets 0x131, 0x132 or any unmapped offset change no register. Unmapped offsets read 0.
- R11: With ECC_PRESENT = 0, control bit0 reads 0, ecc_check_en stays 0 and write data is never altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Register word offset for read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| wr_data_in | input | DATA_W | Write data from the controller |
| wr_data_out | output | DATA_W | Write data towards the encoder, after injection |
| ecc_check_en | output | 1 | ECC generation and checking enable |
| auto_corr_en | output | 1 | Auto-correction enable |
| ev_sbe | input | 1 | Single-bit error event pulse |
| ev_dbe | input | 1 | Double-bit error event pulse |
| ev_drop | input | 1 | Dropped auto-correction event pulse |
| ev_addr | input | 32 | Burst-aligned address of the reported event |
| irq | output | 1 | Error interrupt |

## Verification
The bench drives 260 back-to-back double-bit events and checks the count. A counter that wrapped would read a small number instead of 255. It fires an event in the same cycle as a clear: a design that favoured the event would show a flag and a count of 1 after the clear. It also confirms that bit7 reads 1 for exactly one cycle and that the injection masks do nothing while ECC is off or absent, where a wrong design would keep corrupting data. The interrupt is checked every cycle against a model under random masks and enables. This catches an interrupt that fires a cycle early or that ignores a mask.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
    localparam int CNT_W   = 8;
    localparam int NUM_CLS = 3;
    localparam int REG_AW  = 10;
    localparam int REG_DW  = 32;
    localparam int CTRL_W  = 9;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 10'h130;
    localparam logic [REG_AW-1:0] OFF_STAT  = 10'h131;
    localparam logic [REG_AW-1:0] OFF_EADDR = 10'h132;

    // field order is the register bit order, bit 8 first
    typedef struct packed {
        logic drop_mask;
        logic clear;
        logic dbe_mask;
        logic sbe_mask;
        logic int_en;
        logic inj_dbe;
        logic inj_sbe;
        logic auto_corr;
        logic ecc_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{drop_mask: 1'b0, clear: 1'b0, dbe_mask: 1'b0,
                                     sbe_mask: 1'b0, int_en: 1'b1, inj_dbe: 1'b0,
                                     inj_sbe: 1'b0, auto_corr: 1'b0, ecc_en: 1'b1};

    typedef enum int {CLS_SBE = 0, CLS_DBE = 1, CLS_DROP = 2} ev_cls_e;
endpackage

// File: rtl/ecc_sat_cnt.sv
module ecc_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && cnt_q != MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R5: a full counter stays full
    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == MAX && !clr_i) |=> cnt_o == MAX);

    // R5: one step per event below the limit
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_o != MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/ecc_csr_ctrl.sv
module ecc_csr_ctrl
    import ecc_csr_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter bit ECC_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic              clear_o,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] wr_data_o
);
    ctrl_t             ctrl_d, ctrl_q;
    logic [DATA_W-1:0] inj_mask;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.clear = 1'b0;
        if (wr_i) begin
            ctrl_d = ctrl_t'(wdata_i);
        end
        if (!ECC_PRESENT) begin
            ctrl_d.ecc_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q        <= CTRL_RESET;
            ctrl_q.ecc_en <= ECC_PRESENT;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign clear_o = wr_i & wdata_i[7];
    assign ctrl_o  = ctrl_q;

    always_comb begin
        inj_mask = '0;
        if (ctrl_q.ecc_en) begin
            inj_mask[0] = ctrl_q.inj_sbe | ctrl_q.inj_dbe;
            inj_mask[1] = ctrl_q.inj_dbe;
        end
    end

    assign wr_data_o = wr_data_i ^ inj_mask;

    // R3: no corruption while checking is off
    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o.ecc_en |-> wr_data_o == wr_data_i);

    // R3: upper data bits never altered
    p_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_o[DATA_W-1:2] == wr_data_i[DATA_W-1:2]);

    // R7: clear bit drops after one cycle without a new clearing write
    p_clr_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o.clear && !wr_i) |=> !ctrl_o.clear);
endmodule

// File: rtl/ecc_csr_status.sv
module ecc_csr_status
    import ecc_csr_pkg::*;
#(
    parameter int EA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic [NUM_CLS-1:0]     ev_i,
    input  logic [EA_W-1:0]        ev_addr_i,
    input  logic                   int_en_i,
    input  logic [NUM_CLS-1:0]     mask_i,
    output logic [NUM_CLS*CNT_W+8-1:0] status_o,
    output logic [EA_W-1:0]        err_addr_o,
    output logic                   irq_o
);
    typedef struct packed {
        logic [NUM_CLS-1:0] flag;
        logic [EA_W-1:0]    addr;
        logic               irq;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] cnt [NUM_CLS];

    for (genvar g = 0; g < NUM_CLS; g++) begin : g_cnt
        ecc_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clear_i),
            .inc_i (ev_i[g]),
            .cnt_o (cnt[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            st_d.flag = st_q.flag | ev_i;
            if (ev_i[CLS_SBE] || ev_i[CLS_DBE]) begin
                st_d.addr = ev_addr_i;
            end
            st_d.irq = int_en_i & (|(st_q.flag & ~mask_i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o   = {cnt[CLS_DROP], cnt[CLS_DBE], cnt[CLS_SBE], 5'b0, st_q.flag};
    assign err_addr_o = st_q.addr;
    assign irq_o      = st_q.irq;

    // R4: flags never fall without a clear
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((status_o[NUM_CLS-1:0] & $past(status_o[NUM_CLS-1:0]))
                      == $past(status_o[NUM_CLS-1:0])));

    // R6: address of a single or double error is captured
    p_addr_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_i[CLS_SBE] || ev_i[CLS_DBE]) && !clear_i) |=> err_addr_o == $past(ev_addr_i));

    // R7 and R8: clear wins and wipes everything
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (status_o == '0 && err_addr_o == '0 && !irq_o));

    // R9: no interrupt while disabled
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en_i |=> !irq_o);
endmodule

// File: rtl/ecc_err_csr.sv
module ecc_err_csr
    import ecc_csr_pkg::*;
#(
    parameter int DATA_W      = 64,
    parameter bit ECC_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [9:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [DATA_W-1:0] wr_data_in,
    output logic [DATA_W-1:0] wr_data_out,
    output logic              ecc_check_en,
    output logic              auto_corr_en,
    input  logic              ev_sbe,
    input  logic              ev_dbe,
    input  logic              ev_drop,
    input  logic [31:0]       ev_addr,
    output logic              irq
);
    ctrl_t       ctrl;
    logic        clear;
    logic        ctrl_wr;
    logic [31:0] status;
    logic [31:0] err_addr;
    logic        unused_wbits;

    assign ctrl_wr      = bus_wr && (bus_addr == OFF_CTRL);
    assign unused_wbits = ^bus_wdata[REG_DW-1:CTRL_W];

    ecc_csr_ctrl #(.DATA_W(DATA_W), .ECC_PRESENT(ECC_PRESENT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (ctrl_wr),
        .wdata_i   (bus_wdata[CTRL_W-1:0]),
        .ctrl_o    (ctrl),
        .clear_o   (clear),
        .wr_data_i (wr_data_in),
        .wr_data_o (wr_data_out)
    );

    ecc_csr_status #(.EA_W(32)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .ev_i       ({ev_drop, ev_dbe, ev_sbe}),
        .ev_addr_i  (ev_addr),
        .int_en_i   (ctrl.int_en),
        .mask_i     ({ctrl.drop_mask, ctrl.dbe_mask, ctrl.sbe_mask}),
        .status_o   (status),
        .err_addr_o (err_addr),
        .irq_o      (irq)
    );

    assign ecc_check_en = ctrl.ecc_en;
    assign auto_corr_en = ctrl.auto_corr;

    always_comb begin
        case (bus_addr)
            OFF_CTRL:  bus_rdata = {{(REG_DW-CTRL_W){1'b0}}, ctrl};
            OFF_STAT:  bus_rdata = status;
            OFF_EADDR: bus_rdata = err_addr;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/ecc_err_csr_tb_top.sv
module ecc_err_csr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam logic [9:0] A_CTRL = 10'h130, A_STAT = 10'h131, A_EADDR = 10'h132;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata, rdata_ne;
    logic [DW-1:0] wdin = '0;
    logic [DW-1:0] wdout, wdout_ne;
    logic          chk_en, corr_en, chk_en_ne, corr_en_ne;
    logic          ev_sbe = 1'b0, ev_dbe = 1'b0, ev_drop = 1'b0;
    logic [31:0]   ev_addr = '0;
    logic          irq, irq_ne;

    int checks = 0;
    int errors = 0;

    logic [8:0]  m_ctrl;
    logic [2:0]  m_flag;
    logic [7:0]  m_cnt [3];
    logic [31:0] m_addr;
    logic        m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_err_csr #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_data_in(wdin),
        .wr_data_out(wdout), .ecc_check_en(chk_en), .auto_corr_en(corr_en),
        .ev_sbe(ev_sbe), .ev_dbe(ev_dbe), .ev_drop(ev_drop), .ev_addr(ev_addr), .irq(irq)
    );

    ecc_err_csr #(.DATA_W(DW), .ECC_PRESENT(1'b0)) dut_noecc_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_ne), .wr_data_in(wdin),
        .wr_data_out(wdout_ne), .ecc_check_en(chk_en_ne), .auto_corr_en(corr_en_ne),
        .ev_sbe(ev_sbe), .ev_dbe(ev_dbe), .ev_drop(ev_drop), .ev_addr(ev_addr), .irq(irq_ne)
    );

    function automatic logic [DW-1:0] exp_wd(logic [DW-1:0] d, logic [8:0] c);
        logic [DW-1:0] r = d;
        if (c[0]) begin
            if (c[2] || c[3]) r[0] = ~r[0];
            if (c[3])         r[1] = ~r[1];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_stat();
        return {m_cnt[2], m_cnt[1], m_cnt[0], 5'b0, m_flag};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 9'h011; m_flag = '0; m_addr = '0; m_irq = 1'b0;
        for (int i = 0; i < 3; i++) m_cnt[i] = '0;
    endtask

    task automatic model_edge();
        logic clr;
        logic irq_n;
        logic [2:0] ev;
        clr   = bus_wr && bus_addr == A_CTRL && bus_wdata[7];
        irq_n = !clr && m_ctrl[4] && |(m_flag & ~{m_ctrl[8], m_ctrl[6], m_ctrl[5]});
        ev    = {ev_drop, ev_dbe, ev_sbe};
        if (clr) begin
            m_flag = '0; m_addr = '0;
            for (int i = 0; i < 3; i++) m_cnt[i] = '0;
        end else begin
            m_flag = m_flag | ev;
            for (int i = 0; i < 3; i++)
                if (ev[i] && m_cnt[i] != 8'hFF) m_cnt[i] = m_cnt[i] + 8'd1;
            if (ev_sbe || ev_dbe) m_addr = ev_addr;
        end
        m_irq = irq_n;
        if (bus_wr && bus_addr == A_CTRL) m_ctrl = bus_wdata[8:0];
        else m_ctrl[7] = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        bus_wr = 1'b0; ev_sbe = 1'b0; ev_dbe = 1'b0; ev_drop = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr_ctrl(logic [31:0] v);
        bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = v;
        tick();
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        rd(A_STAT, d);  check({req, " status"}, 64'(d), 64'(exp_stat()));
        rd(A_EADDR, d); check({req, " err_addr"}, 64'(d), 64'(m_addr));
        rd(A_CTRL, d);  check({req, " ctrl"}, 64'(d), 64'({23'b0, m_ctrl}));
        check({req, " irq"}, 64'(irq), 64'(m_irq));
        check({req, " wr_data"}, wdout, exp_wd(wdin, m_ctrl));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int unsigned seed_sink;
        seed_sink = $urandom(32'd7741);
        model_reset();
        wdin = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, d); check("R1 ctrl reset", 64'(d), 64'h11);
        check_all("R1");
        check("R2 ecc_check_en reset", 64'(chk_en), 64'd1);

        // R2 control fields and readback
        wr_ctrl(32'hFFFF_FE03);
        check_all("R2 reserved bits");
        check("R2 auto_corr_en", 64'(corr_en), 64'd1);
        wr_ctrl(32'h0000_0010);
        check("R2 ecc_check_en off", 64'(chk_en), 64'd0);
        check("R2 auto_corr_en off", 64'(corr_en), 64'd0);

        // R3 injection
        wr_ctrl(32'h015); check("R3 single inject", wdout, wdin ^ 64'h1);
        wr_ctrl(32'h019); check("R3 double inject", wdout, wdin ^ 64'h3);
        wr_ctrl(32'h01D); check("R3 both inject", wdout, wdin ^ 64'h3);
        wr_ctrl(32'h01C); check("R3 inject while ecc off", wdout, wdin);
        check("R11 noecc passthru", wdout_ne, wdin);
        wr_ctrl(32'h01D);
        check("R11 noecc check_en", 64'(chk_en_ne), 64'd0);
        check("R11 noecc passthru", wdout_ne, wdin);
        bus_addr = A_CTRL; #1;
        check("R11 noecc bit0", 64'(rdata_ne[0]), 64'd0);
        wr_ctrl(32'h011);

        // R4 R6 R9 single event then interrupt one cycle later
        ev_sbe = 1'b1; ev_addr = 32'hA000_0040;
        tick();
        check_all("R4 R6 flag set");
        check("R9 irq not yet", 64'(irq), 64'd0);
        tick();
        check("R9 irq raised", 64'(irq), 64'd1);
        ev_drop = 1'b1; ev_addr = 32'h5555_0000;
        tick();
        check_all("R6 drop keeps addr");
        ev_dbe = 1'b1; ev_addr = 32'hB000_0080;
        tick();
        check_all("R5 R6 double event");

        // R7 clear and self-clearing bit
        wr_ctrl(32'h091);
        rd(A_CTRL, d); check("R7 clear bit one cycle", 64'(d[7]), 64'd1);
        check_all("R7 after clear");
        tick();
        rd(A_CTRL, d); check("R7 clear bit returns", 64'(d[7]), 64'd0);

        // R8 event coincident with clear
        bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h091;
        ev_dbe = 1'b1; ev_sbe = 1'b1; ev_addr = 32'hDEAD_0000;
        tick();
        rd(A_STAT, d); check("R8 clear wins status", 64'(d), 64'd0);
        rd(A_EADDR, d); check("R8 clear wins addr", 64'(d), 64'd0);

        // R5 saturation
        for (int i = 0; i < 260; i++) begin
            ev_dbe = 1'b1; ev_addr = i;
            tick();
        end
        rd(A_STAT, d); check("R5 saturate", 64'(d[23:16]), 64'd255);
        check_all("R5 saturate");

        // R9 masks and enable
        wr_ctrl(32'h0B1);
        ev_sbe = 1'b1; tick(); tick();
        check("R9 sbe masked", 64'(irq), 64'd0);
        ev_drop = 1'b1; tick(); tick();
        check("R9 drop unmasked", 64'(irq), 64'd1);
        wr_ctrl(32'h001); tick();
        check("R9 int disabled", 64'(irq), 64'd0);
        check_all("R9");
        wr_ctrl(32'h011);

        // R10 read-only and unmapped
        ev_sbe = 1'b1; ev_addr = 32'h1234_5670; tick();
        bus_wr = 1'b1; bus_addr = A_STAT;  bus_wdata = '1; tick();
        bus_wr = 1'b1; bus_addr = A_EADDR; bus_wdata = '1; tick();
        bus_wr = 1'b1; bus_addr = 10'h000; bus_wdata = '1; tick();
        check_all("R10 writes ignored");
        rd(10'h000, d); check("R10 unmapped read", 64'(d), 64'd0);
        rd(10'h133, d); check("R10 unmapped read", 64'(d), 64'd0);

        // random phase
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 6 == 0) begin
                bus_wr = 1'b1; bus_addr = A_CTRL;
                bus_wdata = {23'b0, 9'($urandom) & 9'h17F};
                bus_wdata[7] = ($urandom % 12 == 0);
            end
            ev_sbe  = ($urandom % 4 == 0);
            ev_dbe  = ($urandom % 5 == 0);
            ev_drop = ($urandom % 6 == 0);
            ev_addr = $urandom;
            wdin    = {$urandom, $urandom};
            tick();
            check_all("R3 R4 R5 R6 R9 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule